// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a stream of oscillator tick enables into a one-cycle pulse per second, and it corrects a slow or fast crystal by a signed parts-per-million amount. A 3-bit trim code selects the correction. The high bit is the direction and the two low bits are a magnitude in steps of 10 ppm. The nominal count of ticks that makes one second is a parameter.

The block does not change the divide ratio for good. A fractional accumulator collects the requested correction at every second boundary. Each time that accumulator passes the ppm denominator, exactly one later second is made one tick shorter or one tick longer. Over many seconds the average second length then matches the trim setting.

A new trim code is sampled only at a second boundary, and the correction in effect is reported as a signed value.

Top module: `dtp_seconds_prescaler`

## Requirements
- R1: The trim code is decoded as follows. Bit 2 is the direction: 0 means positive and 1 means negative. Bit 0 is worth 10 ppm and bit 1 is worth 20 ppm. `corr_ppm` is the signed two's-complement value of the code in effect: 000 and 100 give 0, 001/010/011 give +10/+20/+30, and 101/110/111 give -10/-20/-30.
- R2: A second lasts TICKS_PER_SEC ticks when it is not adjusted. `sec_pulse` is high for exactly one clock cycle, in the cycle after the clock edge that accepts the last tick of the second.
- R3: A cycle with `tick_en` low does not advance the second. Only cycles with `tick_en` high are counted.
- R4: `trim_code` is sampled only at the edge that ends a second. `corr_ppm` changes in the same cycle as that `sec_pulse`, and the sampled code governs the accumulation and the following second.
- R5: At every second boundary the block adds |ppm| × TICKS_PER_SEC to a remainder held modulo PPM_DENOM (default 1,000,000). When that sum reaches PPM_DENOM or more, the following second is adjusted by exactly one tick.
- R6: With a positive code, an adjusted second is TICKS_PER_SEC−1 ticks long. With a negative code, it is TICKS_PER_SEC+1 ticks long.
- R7: When bit 2 of the newly sampled code differs from bit 2 of the code in effect, the remainder is cleared before the new amount is added.
- R8: A synchronous active-low reset clears the tick count, the remainder and any pending adjustment, and sets the code in effect to 000. During reset `sec_pulse` is low.
- R9: A code with zero magnitude (000 or 100) never produces an adjusted second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One oscillator tick in this cycle |
| trim_code | input | 3 | Direction bit and magnitude bits of the requested correction |
| sec_pulse | output | 1 | One-cycle pulse at the end of each second |
| corr_ppm | output | 6 | Signed correction in effect, in ppm |

## Verification
The hardest case to reach from the ports is a sign reversal that arrives while the remainder is close to a wrap. The clear must then suppress an adjustment that would otherwise have happened. The bench uses a small denominator and a short second so that a 30 ppm code wraps about every other second. It then flips the direction bit every few seconds at the same time as it gates ticks irregularly. A behavioural model predicts every pulse cycle, so a missing or extra adjusted second appears at once as a pulse that is off by one cycle.

// File: rtl/dtp_pkg.sv
// Package: shared types and trim decoding for the trimmed seconds prescaler.
// Assumes: 3-bit trim codes, with bit 2 as direction and bits 1:0 as 10 ppm steps.
package dtp_pkg;

    typedef enum logic [1:0] {
        ADJ_NONE  = 2'd0,
        ADJ_SHORT = 2'd1,
        ADJ_LONG  = 2'd2
    } adj_e;

    localparam int PPM_STEP = 10;
    localparam int PPM_MAX  = 3 * PPM_STEP;

    // Unsigned ppm magnitude of a trim code: 0, 10, 20 or 30.
    function automatic logic [4:0] trim_mag(input logic [2:0] code);
        return 5'({3'b000, code[1:0]}) * 5'(PPM_STEP);
    endfunction

    // Signed ppm value of a trim code.
    function automatic logic signed [5:0] trim_ppm(input logic [2:0] code);
        logic signed [5:0] m;
        m = signed'({1'b0, trim_mag(code)});
        return code[2] ? -m : m;
    endfunction

endpackage

// File: rtl/dtp_tick_counter.sv
// Module: counts enabled ticks within a second and marks the second boundary.
// Assumes: TICKS_PER_SEC >= 3. The adjustment input stays stable for the whole second.
module dtp_tick_counter
    import dtp_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  adj_e adj,
    output logic boundary,
    output logic sec_pulse
);

    localparam int CW = $clog2(TICKS_PER_SEC + 1);
    localparam logic [CW-1:0] LAST_NOM   = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(TICKS_PER_SEC - 2);
    localparam logic [CW-1:0] LAST_LONG  = CW'(TICKS_PER_SEC);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_idx;

    // Pick the index of the final tick for the current second.
    always_comb begin
        case (adj)
            ADJ_SHORT: last_idx = LAST_SHORT;
            ADJ_LONG:  last_idx = LAST_LONG;
            default:   last_idx = LAST_NOM;
        endcase
    end

    // The boundary is the enabled tick that completes the second.
    always_comb boundary = tick_en && (cnt == last_idx);

    // Advance the tick index on each enabled tick and wrap at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (boundary)    cnt <= '0;
        else if (tick_en)     cnt <= cnt + 1'b1;
    end

    // Register the one-cycle second pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) sec_pulse <= 1'b0;
        else        sec_pulse <= boundary;
    end

    p_pulse_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt));

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_LONG);

endmodule

// File: rtl/dtp_trim_latch.sv
// Module: holds the trim code in effect and reports its signed ppm value.
// Assumes: the boundary input is high for the single edge that ends a second.
module dtp_trim_latch
    import dtp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary,
    input  logic [2:0]        trim_code,
    output logic [2:0]        active_code,
    output logic signed [5:0] corr_ppm
);

    // Take the requested code only at a second boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)        active_code <= 3'b000;
        else if (boundary) active_code <= trim_code;
    end

    // Report the signed correction of the code in effect.
    always_comb corr_ppm = trim_ppm(active_code);

    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(active_code));

    p_ppm_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_ppm <= 6'sd30) && (corr_ppm >= -6'sd30));

endmodule

// File: rtl/dtp_frac_accum.sv
// Module: fractional ppm remainder that decides which seconds get one tick more or less.
// Assumes: PPM_MAX * TICKS_PER_SEC < PPM_DENOM, so the remainder wraps at most once per second.
module dtp_frac_accum
    import dtp_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int PPM_DENOM     = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic [2:0] next_code,
    input  logic [2:0] active_code,
    output adj_e       adj
);

    localparam int AW = $clog2(PPM_DENOM);
    localparam int SW = AW + 1;

    logic [AW-1:0] acc;
    logic [SW-1:0] base;
    logic [SW-1:0] step;
    logic [SW-1:0] sum;
    logic          wrap;
    logic          sign_flip;

    // Add the per-second increment to the remainder, cleared first if the direction changes.
    always_comb begin
        sign_flip = next_code[2] != active_code[2];
        base      = sign_flip ? '0 : SW'(acc);
        step      = SW'(trim_mag(next_code)) * SW'(TICKS_PER_SEC);
        sum       = base + step;
        wrap      = sum >= SW'(PPM_DENOM);
    end

    // Update the remainder and the adjustment for the next second at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            adj <= ADJ_NONE;
        end else if (boundary) begin
            acc <= wrap ? AW'(sum - SW'(PPM_DENOM)) : AW'(sum);
            if (!wrap)             adj <= ADJ_NONE;
            else if (next_code[2]) adj <= ADJ_LONG;
            else                   adj <= ADJ_SHORT;
        end
    end

    p_acc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc < AW'(PPM_DENOM));

    p_zero_no_adjust_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && next_code[1:0] == 2'b00) |=> adj == ADJ_NONE);

endmodule

// File: rtl/dtp_seconds_prescaler.sv
// Module: top of the trimmed seconds prescaler.
// It joins the tick counter, the trim latch and the fractional accumulator.
// Assumes: tick_en marks oscillator ticks in the clk domain and rst_n is synchronous.
module dtp_seconds_prescaler
    import dtp_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000,
    parameter int PPM_DENOM     = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [2:0]        trim_code,
    output logic              sec_pulse,
    output logic signed [5:0] corr_ppm
);

    logic       boundary;
    logic [2:0] active_code;
    adj_e       adj;

    dtp_tick_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .adj       (adj),
        .boundary  (boundary),
        .sec_pulse (sec_pulse)
    );

    dtp_trim_latch u_trim (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (boundary),
        .trim_code   (trim_code),
        .active_code (active_code),
        .corr_ppm    (corr_ppm)
    );

    dtp_frac_accum #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .PPM_DENOM     (PPM_DENOM)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .boundary    (boundary),
        .next_code   (trim_code),
        .active_code (active_code),
        .adj         (adj)
    );

    p_adj_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adj == ADJ_SHORT) |-> !active_code[2]);

    p_adj_dir_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adj == ADJ_LONG) |-> active_code[2]);

endmodule

// File: tb/dtp_seconds_prescaler_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model is stepped on every clock and compared on every negative edge.
module dtp_seconds_prescaler_tb;

    localparam int TPS   = 16;
    localparam int DENOM = 1000;
    localparam int WDOG  = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic [2:0]        trim_code = 3'b000;
    logic              sec_pulse;
    logic signed [5:0] corr_ppm;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    // Reference model state.
    int       m_cnt = 0;
    int       m_len = TPS;
    int       m_acc = 0;
    bit [2:0] m_code = 3'b000;
    bit       m_pulse = 1'b0;

    // Gap measurement between pulses.
    int last_pulse = 0;
    int gap_short = 0;
    int gap_long = 0;

    dtp_seconds_prescaler #(.TICKS_PER_SEC(TPS), .PPM_DENOM(DENOM)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .trim_code (trim_code),
        .sec_pulse (sec_pulse),
        .corr_ppm  (corr_ppm)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_ppm(input bit [2:0] c);
        int mag;
        mag = 10 * int'(c[1:0]);
        return c[2] ? -mag : mag;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R2 watchdog: cycles %0d expected below %0d", cyc, WDOG);
            summary();
        end
    end

    task automatic compare(input string tag);
        vectors++;
        if (sec_pulse !== m_pulse) begin
            fails++;
            $display("FAIL %s sec_pulse at cycle %0d: got %0b expected %0b", tag, cyc, sec_pulse, m_pulse);
        end
        vectors++;
        if (int'(corr_ppm) != exp_ppm(m_code)) begin
            fails++;
            $display("FAIL %s corr_ppm at cycle %0d: got %0d expected %0d", tag, cyc, corr_ppm, exp_ppm(m_code));
        end
        if (sec_pulse === 1'b1) begin
            if (cyc - last_pulse == TPS - 1) gap_short++;
            if (cyc - last_pulse == TPS + 1) gap_long++;
            last_pulse = cyc;
        end
    endtask

    task automatic step_model(input bit r, input bit t, input bit [2:0] c);
        int s;
        m_pulse = 1'b0;
        if (!r) begin
            m_cnt = 0; m_len = TPS; m_acc = 0; m_code = 3'b000;
        end else if (t) begin
            if (m_cnt == m_len - 1) begin
                m_cnt = 0;
                m_pulse = 1'b1;
                s = ((c[2] != m_code[2]) ? 0 : m_acc) + 10 * int'(c[1:0]) * TPS;
                if (s >= DENOM) begin
                    s -= DENOM;
                    m_len = c[2] ? TPS + 1 : TPS - 1;
                end else begin
                    m_len = TPS;
                end
                m_acc = s;
                m_code = c;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic cycle(input bit r, input bit t, input bit [2:0] c, input string tag);
        @(negedge clk);
        compare(tag);
        rst_n = r; tick_en = t; trim_code = c;
        @(posedge clk);
        step_model(r, t, c);
    endtask

    task automatic run(input int n, input int pct, input bit [2:0] c, input string tag);
        for (int i = 0; i < n; i++) cycle(1'b1, ($urandom % 100) < pct, c, tag);
    endtask

    initial begin
        // R8: reset state.
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 3'b011, "R8");
        // R2: nominal seconds with a tick on every cycle.
        run(80, 100, 3'b000, "R2");
        // R3: irregular tick enables.
        run(200, 40, 3'b000, "R3");
        // R5 and R6: positive 30 ppm shortens some seconds.
        gap_short = 0;
        run(400, 100, 3'b011, "R5");
        vectors++;
        if (gap_short == 0) begin
            fails++;
            $display("FAIL R6 short seconds: got %0d expected above 0", gap_short);
        end
        // R6: negative 20 ppm lengthens some seconds.
        gap_long = 0;
        run(500, 100, 3'b110, "R6");
        vectors++;
        if (gap_long == 0) begin
            fails++;
            $display("FAIL R6 long seconds: got %0d expected above 0", gap_long);
        end
        // R7: the direction bit flips every few seconds under irregular ticks.
        for (int k = 0; k < 12; k++) run(45, 70, (k % 2) ? 3'b111 : 3'b011, "R7");
        // R4: the code changes in the middle of seconds.
        for (int k = 0; k < 40; k++) run(7, 80, 3'($urandom), "R4");
        // R1: sweep all codes.
        for (int c = 0; c < 8; c++) run(60, 100, 3'(c), "R1");
        // R9: zero-magnitude codes never adjust.
        gap_short = 0; gap_long = 0;
        for (int k = 0; k < 8; k++) run(50, 100, (k % 2) ? 3'b100 : 3'b000, "R9");
        vectors++;
        if (gap_short + gap_long > 1) begin
            fails++;
            $display("FAIL R9 adjusted seconds: got %0d expected at most 1", gap_short + gap_long);
        end
        // R8: reset in the middle of a run.
        run(37, 100, 3'b011, "R8");
        for (int i = 0; i < 2; i++) cycle(1'b0, 1'b1, 3'b011, "R8");
        run(60, 100, 3'b101, "R8");
        done = 1'b1;
        summary();
    end

endmodule